// File: doc/BRIEF.md
# Not-Recently-Used Victim Selector

This block holds the replacement state for one set of a set-associative cache with four or eight ways, chosen by a parameter. Each way has one usage flag. A flag is set when its way is hit or filled. A victim for a new fill is always drawn from the ways whose flag is still clear. Ways are never reordered. Recency is only approximated. When setting a flag would leave every way flagged, the flags are cleared at once. Only the way or ways touched in that cycle stay flagged, so a line that was just used is not evicted next.

The surrounding cache detects hits and drives `hit_valid` with the hit way's index. It drives `alloc_req` when it fills a line. In that same cycle it uses the combinational `victim_way` output as the way to write. The flags are updated at the next clock edge. `use_bits` exposes the flag vector, which the cache may use for debug or for an outer policy.

The block has no sequencer. Every access is handled within a single cycle. The update is classified as one of four access kinds:

| Kind | Inputs in that cycle |
|---|---|
| `ACC_NONE` | neither input asserted |
| `ACC_HIT` | `hit_valid` only |
| `ACC_ALLOC` | `alloc_req` only |
| `ACC_BOTH` | `hit_valid` and `alloc_req` together |

Each kind moves the flag register to its next value in the same cycle.

Top module: `nru_victim_sel`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, all usage flags are 0 and `victim_way` is 0.
- R2: With `hit_valid` high, bit `hit_way` of `use_bits` is 1 after the next rising clock edge.
- R3: `victim_way` is the lowest index i for which `use_bits[i]` is 0.
- R4: With `alloc_req` high, the way shown on `victim_way` in that cycle has its flag set to 1 after the next edge.
- R5: When the flags OR-ed with this cycle's accessed ways would be all ones, the next value holds only the accessed ways' flags.
- R6: `victim_way` never names a way whose flag is 1.
- R7: `use_bits` is never all ones after a clock edge.
- R8: A hit and an allocate in the same cycle both set their flags before the saturation rule of R5 is applied.
- R9: With neither `hit_valid` nor `alloc_req` high, `use_bits` keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A hit occurred on `hit_way` this cycle |
| hit_way | input | WAY_W | Index of the hit way |
| alloc_req | input | 1 | Fill this cycle into `victim_way` |
| victim_way | output | WAY_W | Lowest-indexed way whose flag is clear |
| use_bits | output | WAYS | Current usage flags, bit i for way i |

## Verification
The embedded assertions check four properties on every cycle:
- the victim's flag is always clear;
- the flags are never all set;
- a hit or a fill always leaves its way flagged at the next edge;
- an idle cycle leaves the flags unchanged.

The following are shown only by the bench's scenarios, which compare against an arithmetic model of the flags:
- the exact value after a saturation clear, where only the accessed ways survive;
- the lowest-index victim choice;
- the combined effect of a hit and a fill in the same cycle;
- the reset state.

// File: rtl/nru_pkg.sv
package nru_pkg;

    // Kind of access presented to the flag register in one cycle
    typedef enum logic [1:0] {
        ACC_NONE  = 2'b00,
        ACC_HIT   = 2'b01,
        ACC_ALLOC = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_kind_e;

endpackage

// File: rtl/nru_victim_pick.sv
module nru_victim_pick #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  use_bits,
    output logic [WAY_W-1:0] victim
);

    // Fixed-priority search: the lowest clear flag wins
    always_comb begin
        victim = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!use_bits[i]) begin
                victim = WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/nru_mark.sv
module nru_mark
    import nru_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  use_bits,
    input  logic             hit_valid,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             alloc_req,
    input  logic [WAY_W-1:0] alloc_way,
    output logic [WAYS-1:0]  next_bits
);

    localparam logic [WAYS-1:0] ALL_SET = '1;

    acc_kind_e       kind;
    logic [WAYS-1:0] hit_mask;
    logic [WAYS-1:0] alloc_mask;
    logic [WAYS-1:0] touched;
    logic [WAYS-1:0] merged;

    assign kind = acc_kind_e'({alloc_req, hit_valid});

    // Decode both way indices into one-hot masks
    always_comb begin
        hit_mask   = '0;
        alloc_mask = '0;
        hit_mask[hit_way]     = 1'b1;
        alloc_mask[alloc_way] = 1'b1;
    end

    // Select which ways are touched this cycle
    always_comb begin
        unique case (kind)
            ACC_NONE:  touched = '0;
            ACC_HIT:   touched = hit_mask;
            ACC_ALLOC: touched = alloc_mask;
            ACC_BOTH:  touched = hit_mask | alloc_mask;
            default:   touched = '0;
        endcase
    end

    // Mark first, then apply the saturation clear that keeps only touched ways
    always_comb begin
        merged    = use_bits | touched;
        next_bits = (merged == ALL_SET) ? touched : merged;
    end

endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_valid,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             alloc_req,
    output logic [WAY_W-1:0] victim_way,
    output logic [WAYS-1:0]  use_bits
);

    localparam logic [WAYS-1:0] ALL_SET = '1;

    logic [WAYS-1:0]  use_q;
    logic [WAYS-1:0]  use_d;
    logic [WAY_W-1:0] pick;

    nru_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
        .use_bits (use_q),
        .victim   (pick)
    );

    nru_mark #(.WAYS(WAYS), .WAY_W(WAY_W)) u_mark (
        .use_bits  (use_q),
        .hit_valid (hit_valid),
        .hit_way   (hit_way),
        .alloc_req (alloc_req),
        .alloc_way (pick),
        .next_bits (use_d)
    );

    // Flag register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_q <= '0;
        end else begin
            use_q <= use_d;
        end
    end

    // Outputs
    always_comb begin
        victim_way = pick;
        use_bits   = use_q;
    end

    assert_victim_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !use_q[victim_way]);

    assert_never_saturated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        use_q != ALL_SET);

    assert_hit_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> use_q[$past(hit_way)]);

    assert_alloc_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |=> use_q[$past(victim_way)]);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_valid && !alloc_req) |=> $stable(use_q));

endmodule

// File: tb/nru_victim_sel_bench.sv
module nru_victim_sel_bench;

    localparam int WAYS  = 4;
    localparam int WAY_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hit_valid = 1'b0;
    logic [WAY_W-1:0] hit_way = '0;
    logic             alloc_req = 1'b0;
    logic [WAY_W-1:0] victim_way;
    logic [WAYS-1:0]  use_bits;

    int n_checks = 0;
    int n_fail   = 0;
    logic [WAYS-1:0] model = '0;

    always #2 clk = ~clk;

    nru_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_nru_victim_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_valid  (hit_valid),
        .hit_way    (hit_way),
        .alloc_req  (alloc_req),
        .victim_way (victim_way),
        .use_bits   (use_bits)
    );

    function automatic logic [WAY_W-1:0] lowest_clear(input logic [WAYS-1:0] b);
        logic [WAY_W-1:0] v = '0;
        for (int i = WAYS - 1; i >= 0; i--) if (!b[i]) v = WAY_W'(i);
        return v;
    endfunction

    task automatic check_now(input string tag);
        n_checks++;
        if (use_bits !== model) begin
            n_fail++;
            $display("FAIL %s use_bits actual=%b expected=%b", tag, use_bits, model);
        end
        n_checks++;
        if (victim_way !== lowest_clear(model)) begin
            n_fail++;
            $display("FAIL %s victim_way actual=%0d expected=%0d", tag, victim_way,
                     lowest_clear(model));
        end
    endtask

    // Check current outputs, then present one access and advance the model
    task automatic step(input logic hv, input logic [WAY_W-1:0] hw, input logic ar,
                        input string tag);
        logic [WAYS-1:0] acc;
        logic [WAYS-1:0] m;
        @(negedge clk);
        check_now(tag);
        hit_valid = hv;
        hit_way   = hw;
        alloc_req = ar;
        acc = '0;
        if (hv) acc[hw] = 1'b1;
        if (ar) acc[lowest_clear(model)] = 1'b1;
        m = model | acc;
        model = (m == '1) ? acc : m;
    endtask

    initial begin
        #400000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        check_now("R1 in reset");
        rst_n = 1'b1;
        model = '0;
        step(1'b0, 2'd0, 1'b0, "R1 after reset");
        // R2: hits mark ways 1 and 3; R3 victim stays at way 0
        step(1'b1, 2'd1, 1'b0, "R2");
        step(1'b1, 2'd3, 1'b0, "R2 hit way1");
        // R9: idle cycles hold state
        step(1'b0, 2'd2, 1'b0, "R2 hit way3");
        step(1'b0, 2'd0, 1'b0, "R9 idle");
        // R4: fill into lowest clear (way 0), then R3 victim becomes way 2
        step(1'b0, 2'd0, 1'b1, "R9 idle hold");
        step(1'b0, 2'd0, 1'b0, "R4 alloc way0");
        // R5: fill into way 2 saturates; only way 2 survives
        step(1'b0, 2'd0, 1'b1, "R3 victim way2");
        step(1'b0, 2'd0, 1'b0, "R5 saturation keeps way2");
        // R8: hit on way 3 and fill into way 0 together
        step(1'b1, 2'd3, 1'b1, "R8 pre");
        step(1'b1, 2'd1, 1'b0, "R8 hit+alloc");
        // R5/R8: hit way1 saturates, leaving only way1
        step(1'b0, 2'd0, 1'b0, "R5 hit saturation");
        step(1'b0, 2'd0, 1'b0, "R5 after hit saturation");
        // Hit on an already set way is harmless
        step(1'b1, 2'd1, 1'b0, "R2 repeat hit");
        // Near-exhaustive sweep over all access kinds and ways
        for (int k = 0; k < 4000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[2:1], lfsr[3], "R8 sweep");
        end
        // Mid-run reset returns to the cleared state
        @(negedge clk);
        rst_n = 1'b0;
        hit_valid = 1'b0;
        alloc_req = 1'b0;
        model = '0;
        @(negedge clk);
        check_now("R1 re-reset");
        rst_n = 1'b1;
        step(1'b0, 2'd0, 1'b0, "R1 after re-reset");
        step(1'b0, 2'd0, 1'b0, "R9 final");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule